// File: doc/BRIEF.md
# Round-Robin Replicated Pipeline Stage

This block is one stage of a synchronous pipeline whose operation takes several clock cycles. To keep one token per cycle flowing, the operation is copied into `SLICES` parallel slices. A front mixer sends each accepted token to the next slice in turn. A rear mixer takes finished results back in the same rotating order. Tokens therefore always leave the stage in the order they arrived, even though each slice works on its own.

Both sides use a valid/ready handshake carrying a `DATA_W`-bit word. Each slice latches its token on the accepting edge, so the input is free again straight away. The slice then counts `LAT` cycles before it offers its result. The slice transform is a stand-in for real arithmetic. It rotates the word left by one bit and then XORs it with the parameter `KEY`. When `SLICES` is at least `LAT`, the stage keeps up a rate of one token per cycle.

Top module: `wag_stage`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1. Both pointers point at slice 0.
- R2: Accepted tokens go to slices 0, 1, …, SLICES-1 and then back to 0. The dispatch pointer moves on each input handshake and at no other time.
- R3: `in_ready` is 1 exactly when the slice under the dispatch pointer is empty, or holds a result that leaves on this cycle's output handshake.
- R4: Each output word equals its input word rotated left by one bit and then XORed with `KEY` (default 16'hA5C3 for `DATA_W`=16).
- R5: Take a token accepted at clock edge t into an otherwise empty stage. Its result is first offered on `out_valid` after edge t+LAT-1, which means it can leave at edge t+LAT at the earliest.
- R6: Output words appear in exactly the order their inputs were accepted. The collect pointer moves on each output handshake and wraps after SLICES-1.
- R7: If `SLICES` ≥ `LAT`, `out_ready` stays high and input is offered every cycle, then `in_ready` never drops.
- R8: If `out_valid` is high and `out_ready` is low, the next cycle has `out_valid` high with the same `out_data`.
- R9: The stage holds at most `SLICES` tokens. With `out_ready` low it accepts exactly `SLICES` tokens and then stalls. No token is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input token offered |
| in_ready | output | 1 | Stage can take the offered token |
| in_data | input | DATA_W | Input token word |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | DATA_W | Result word |

## Verification
A single isolated token, sent with the output stalled, measures the cycle at which the result first appears. This separates a correct latency from one that is off by one. A back-to-back stream with the output always ready shows whether the rear slot can be reused on the same cycle; without that the rate falls to three tokens in four. A fill-to-capacity run with the output held off, followed by single releases, checks the slice count and also checks that dispatch resumes at the slot just freed. Long runs with random stalls on both sides are compared against a queue of transformed inputs, which shows up any reordering, loss or duplication.

// File: rtl/wag_pkg.sv
package wag_pkg;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_BUSY = 2'd1,
        SL_DONE = 2'd2
    } slice_st_e;

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/wag_slice.sv
module wag_slice
    import wag_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter int          LAT    = 3,
    parameter logic [DATA_W-1:0] KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              free,
    output logic              done,
    output logic [DATA_W-1:0] res
);
    localparam int CNT_W = (LAT > 2) ? $clog2(LAT - 1) : 1;
    localparam int LAST  = (LAT > 1) ? LAT - 2 : 0;

    slice_st_e        st;
    logic [CNT_W-1:0] cnt;

    function automatic logic [DATA_W-1:0] xform(input logic [DATA_W-1:0] d);
        return {d[DATA_W-2:0], d[DATA_W-1]} ^ KEY;
    endfunction

    assign done = (st == SL_DONE);
    assign free = (st == SL_IDLE) || (done && take);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SL_IDLE;
            cnt <= '0;
            res <= '0;
        end else if (load) begin
            res <= xform(in_data);
            cnt <= '0;
            st  <= (LAT == 1) ? SL_DONE : SL_BUSY;
        end else if (st == SL_BUSY) begin
            if (cnt == CNT_W'(LAST)) st <= SL_DONE;
            else                     cnt <= cnt + 1'b1;
        end else if (done && take) begin
            st <= SL_IDLE;
        end
    end

endmodule

// File: rtl/wag_dispatch.sv
module wag_dispatch
    import wag_pkg::*;
#(
    parameter int SLICES = 3,
    parameter int PTR_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SLICES-1:0] free,
    output logic              in_ready,
    output logic [SLICES-1:0] load,
    output logic [PTR_W-1:0]  dptr
);
    logic acc;

    assign in_ready = free[dptr];
    assign acc      = in_valid && in_ready;

    for (genvar i = 0; i < SLICES; i++) begin : g_load
        assign load[i] = acc && (dptr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)      dptr <= '0;
        else if (acc) dptr <= PTR_W'(ring_next(int'(dptr), SLICES));
    end

endmodule

// File: rtl/wag_collect.sv
module wag_collect
    import wag_pkg::*;
#(
    parameter int SLICES = 3,
    parameter int DATA_W = 16,
    parameter int PTR_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SLICES-1:0]             done,
    input  logic [SLICES-1:0][DATA_W-1:0] res,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_data,
    output logic [SLICES-1:0]             take,
    output logic [PTR_W-1:0]              cptr
);
    logic pop;

    assign out_valid = done[cptr];
    assign out_data  = res[cptr];
    assign pop       = out_valid && out_ready;

    for (genvar i = 0; i < SLICES; i++) begin : g_take
        assign take[i] = pop && (cptr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)      cptr <= '0;
        else if (pop) cptr <= PTR_W'(ring_next(int'(cptr), SLICES));
    end

endmodule

// File: rtl/wag_stage.sv
module wag_stage
    import wag_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter int                SLICES = 3,
    parameter int                LAT    = 3,
    parameter logic [DATA_W-1:0] KEY    = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int PTR_W = (SLICES > 1) ? $clog2(SLICES) : 1;

    logic [SLICES-1:0]             free, done, load, take;
    logic [SLICES-1:0][DATA_W-1:0] res;
    logic [PTR_W-1:0]              dptr, cptr;

    wag_dispatch #(.SLICES(SLICES), .PTR_W(PTR_W)) u_disp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .free(free),
        .in_ready(in_ready), .load(load), .dptr(dptr)
    );

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        wag_slice #(.DATA_W(DATA_W), .LAT(LAT), .KEY(KEY)) u_slice (
            .clk(clk), .rst(rst), .load(load[i]), .in_data(in_data),
            .take(take[i]), .free(free[i]), .done(done[i]), .res(res[i])
        );
    end

    wag_collect #(.SLICES(SLICES), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_coll (
        .clk(clk), .rst(rst), .done(done), .res(res), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .take(take), .cptr(cptr)
    );

endmodule

// File: rtl/wag_stage_chk.sv
module wag_stage_chk #(
    parameter int SLICES = 3,
    parameter int DATA_W = 16,
    parameter int PTR_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [PTR_W-1:0]  dptr,
    input logic [PTR_W-1:0]  cptr
);
    localparam int OCC_W = $clog2(SLICES + 1) + 1;

    logic             acc, pop;
    logic [OCC_W-1:0] occ;

    assign acc = in_valid && in_ready;
    assign pop = out_valid && out_ready;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (int'(p) == SLICES - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + OCC_W'(acc) - OCC_W'(pop);
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready && dptr == '0 && cptr == '0));

    a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
        acc |=> dptr == step_ptr($past(dptr)));

    a_r2_hold_ptr: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(dptr));

    a_r6_collect_rotate: assert property (@(posedge clk) disable iff (rst)
        pop |=> cptr == step_ptr($past(cptr)));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r9_capacity: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(SLICES));

    a_r9_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !out_valid);

endmodule

bind wag_stage wag_stage_chk #(.SLICES(SLICES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dptr(dptr), .cptr(cptr)
);

// File: tb/tb_wag_stage.sv
`timescale 1ns/1ps
module tb_wag_stage;
    localparam int DW  = 16;
    localparam int NS  = 3;
    localparam int LT  = 3;
    localparam logic [DW-1:0] K = 16'hA5C3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [DW-1:0] out_data;

    int vec = 0, bad = 0;
    logic [DW-1:0] q[$];
    logic prev_stall = 1'b0;
    logic [DW-1:0] prev_data = '0;
    logic last_acc, last_pop;

    always #5 clk = ~clk;

    wag_stage #(.DATA_W(DW), .SLICES(NS), .LAT(LT), .KEY(K)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic logic [DW-1:0] ref_xf(input logic [DW-1:0] d);
        return {d[DW-2:0], d[DW-1]} ^ K;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic iv, input logic [DW-1:0] id, input logic ordy);
        @(negedge clk);
        in_valid = iv; in_data = id; out_ready = ordy;
        #1;
        if (prev_stall) begin
            chk(out_valid == 1'b1, "R8 valid held", longint'(out_valid), 1);
            chk(out_data == prev_data, "R8 data held", longint'(out_data), longint'(prev_data));
        end
        last_acc = iv && in_ready;
        last_pop = out_valid && ordy;
        if (last_pop) begin
            if (q.size() == 0) chk(1'b0, "R9 extra output", longint'(out_data), 0);
            else begin
                logic [DW-1:0] e;
                e = q.pop_front();
                chk(out_data == e, "R4/R6 output word", longint'(out_data), longint'(e));
            end
        end
        if (last_acc) q.push_back(ref_xf(id));
        prev_stall = out_valid && !ordy;
        prev_data  = out_data;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && q.size() != 0; i++) step(1'b0, '0, 1'b1);
        chk(q.size() == 0, "R9 all tokens out", q.size(), 0);
        step(1'b0, '0, 1'b1);
        chk(out_valid == 1'b0, "R9 no duplicate", longint'(out_valid), 0);
    endtask

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int accn;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);

        // R5: latency of a lone token
        step(1'b1, 16'h1234, 1'b0);
        for (int j = 0; j < LT; j++) begin
            step(1'b0, '0, 1'b0);
            chk(out_valid == (j >= LT - 1), "R5 latency", longint'(out_valid), longint'(j >= LT - 1));
        end
        drain();

        // R7: streaming throughput
        for (int i = 0; i < 30; i++) begin
            step(1'b1, DW'(16'h0100 + i * 16'h0111), 1'b1);
            chk(last_acc == 1'b1, "R7 back-to-back accept", longint'(last_acc), 1);
        end
        drain();

        // R9 / R3 / R2: fill with output stalled, then release one at a time
        accn = 0;
        for (int i = 0; i < NS + 3; i++) begin
            step(1'b1, DW'(16'hC000 + i), 1'b0);
            if (last_acc) accn++;
        end
        chk(accn == NS, "R9 capacity", accn, NS);
        chk(in_ready == 1'b0, "R3 full blocks input", longint'(in_ready), 0);
        step(1'b1, 16'hBEEF, 1'b1);
        chk(in_ready == 1'b1, "R3 ready while popping target slot", longint'(in_ready), 1);
        step(1'b1, 16'hBEF0, 1'b0);
        chk(in_ready == 1'b0, "R2 dispatch moved to next full slot", longint'(in_ready), 0);
        drain();

        // R4 / R6 / R8: random stalls on both sides
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, DW'($urandom), ($urandom % 3) != 0);
        drain();
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) == 0, DW'($urandom), ($urandom % 2) == 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule